// File: doc/BRIEF.md
# Periodic Multi-Device Sync Generator

This block keeps a group of identical interpolating devices aligned in time. A free-running down-counter, loaded from byte-wide period registers, produces a terminal-count pulse once per programmed period. That pulse, the synchronized sync-in level, a constant, or nothing can be routed to the sync-out pin. A software one-shot can add a single pulse on sync-out. In a multi-device system, the master's sync-out is wired to every device's sync-in.

Four internal subsystems each get a clear strobe: the interpolation phase counter, the oscillator, the dither generator and the filter flush. A 2-bit selector per subsystem decides what that subsystem reacts to.

In periodic operation, only the phase counter selector follows sync-in, and the other three are set to never. The master's terminal count then re-aligns every device's phase counter and leaves the oscillator and dither state alone. The period should be a multiple of the interpolation factor N, typically 128·N clocks.

The recommended start-up order has four steps:
1. Configure every device normally.
2. Fire one one-shot from the master.
3. Wait 8 clocks, then set the selectors in every device.
4. Switch the master's sync-out source to terminal count last.

Configuration arrives through a plain single-cycle write port. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `psync_gen`

## Requirements
- R1: After a synchronous active-high reset, sync_out is low and every sub_clr bit is low. In this state all selectors and the sync-out source are 0, and the one-shot is disabled.
- R2: The register map is:
  - Address 0: bits [1:0] are the sync-out source and bit 2 is the one-shot enable.
  - Address 1: four 2-bit selectors. Bits [1:0] drive sub_clr[0] (phase), [3:2] drive sub_clr[1] (oscillator), [5:4] drive sub_clr[2] (dither) and [7:6] drive sub_clr[3] (flush).
  - Addresses 2 and 3: the low and high bytes of the period value V.
  - Address 4: the one-shot trigger, bit 0.
- R3: Writing address 3 reloads the counter with V at that clock edge. The terminal-count pulse then first appears V+1 clocks later and repeats every V+1 clocks.
- R4: For V ≥ 1, the terminal-count pulse lasts exactly one clock.
- R5: Sync-out source encoding is as follows:
  - 0 holds sync_out low.
  - 1 passes the synchronized sync_in level, delayed by two clocks.
  - 2 passes the terminal-count pulse.
  - 3 holds sync_out high.
- R6: With selector value 1, a rising edge on sync_in produces one single-cycle strobe. The strobe is high in the cycle after the third clock edge that samples sync_in high, and a held level gives no further strobes.
- R7: With selector value 2, the strobe is high for one clock, one clock after each terminal-count pulse.
- R8: With selector value 3, the strobe stays high continuously, starting one clock after the selector is written.
- R9: With selector value 0, the strobe never fires, whatever sync_in or the counter does.
- R10: With the one-shot enabled, writing 1 to address 4 bit 0 puts a single-cycle high on sync_out in the clock after the write. This pulse is ORed with the selected source, and the trigger bit clears itself.
- R11: With the one-shot disabled, a one-shot write leaves sync_out unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| sync_in | input | 1 | Asynchronous sync input from the master |
| sync_out | output | 1 | Sync output to other devices |
| sub_clr | output | 4 | Per-subsystem clear strobes (phase, oscillator, dither, flush) |

## Verification
The embedded properties check several behaviours on every cycle:
- the terminal-count pulse never lasts more than one clock;
- the counter reloads the stored period after reaching zero, and loads the written value on restart;
- a sync_in edge is never detected twice in a row;
- a "never" selector keeps its strobe low;
- an "always" selector keeps its strobe high;
- a terminal-count selector strobes after every pulse;
- the one-shot pulse is single-cycle.

Other behaviours only the bench scenarios can show:
- the exact period for each programmed value and the first-pulse position after a reload;
- the cycle at which a sync_in edge reaches each strobe;
- the two-clock latency of the sync_in pass-through;
- that a disabled one-shot leaves sync_out untouched.

// File: rtl/psync_gen_pkg.sv
package psync_gen_pkg;
  typedef enum logic [1:0] {
    SEL_NEVER  = 2'd0,
    SEL_SYNCIN = 2'd1,
    SEL_TC     = 2'd2,
    SEL_ALWAYS = 2'd3
  } sel_e;

  localparam int SEL_W    = 2;
  localparam int NUM_SUB  = 4;
  localparam int BYTE_W   = 8;
  localparam int CNT_W    = 16;
  localparam int ADDR_W   = 3;
endpackage

// File: rtl/sg_regs.sv
module sg_regs
  import psync_gen_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int CW   = CNT_W,
  parameter int NSUB = NUM_SUB
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [BYTE_W-1:0]    wr_data,
  output sel_e                 out_src,
  output logic                 os_en,
  output logic [NSUB*SEL_W-1:0] sel_vec,
  output logic [CW-1:0]        reload,
  output logic                 restart,
  output logic [CW-1:0]        restart_val,
  output logic                 os_pulse
);
  localparam int NBYTES = CW / BYTE_W;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_SEL  = AW'(1);
  localparam logic [AW-1:0] A_CNT0 = AW'(2);
  localparam logic [AW-1:0] A_CTOP = AW'(2 + NBYTES - 1);
  localparam logic [AW-1:0] A_OS   = AW'(2 + NBYTES);

  logic [1:0]             src_q;
  logic                   os_en_q;
  logic [NSUB*SEL_W-1:0]  sel_q;
  logic [BYTE_W-1:0]      cnt_b [NBYTES];
  logic                   os_hit;

  assign os_hit = wr_en && (wr_addr == A_OS) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= 2'd0;
      os_en_q  <= 1'b0;
      sel_q    <= '0;
      os_pulse <= 1'b0;
      for (int i = 0; i < NBYTES; i++) cnt_b[i] <= '1;
    end else begin
      os_pulse <= os_hit;
      if (wr_en) begin
        if (wr_addr == A_CTRL) begin
          src_q   <= wr_data[1:0];
          os_en_q <= wr_data[2];
        end
        if (wr_addr == A_SEL) sel_q <= wr_data[NSUB*SEL_W-1:0];
        for (int i = 0; i < NBYTES; i++)
          if (wr_addr == A_CNT0 + AW'(i)) cnt_b[i] <= wr_data;
      end
    end
  end

  assign restart = wr_en && (wr_addr == A_CTOP);

  for (genvar g = 0; g < NBYTES; g++) begin : g_bytes
    assign reload[g*BYTE_W +: BYTE_W] = cnt_b[g];
    if (g == NBYTES - 1) begin : g_top
      assign restart_val[g*BYTE_W +: BYTE_W] = wr_data;
    end else begin : g_low
      assign restart_val[g*BYTE_W +: BYTE_W] = cnt_b[g];
    end
  end

  assign out_src = sel_e'(src_q);
  assign os_en   = os_en_q;
  assign sel_vec = sel_q;

  // R10: the one-shot pulse lasts a single clock unless triggered again
  a_r10_oneshot_single: assert property (@(posedge clk) disable iff (rst)
    (os_pulse && !os_hit) |=> !os_pulse);
endmodule

// File: rtl/sg_counter.sv
module sg_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] reload,
  input  logic          restart,
  input  logic [CW-1:0] restart_val,
  output logic          tc
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '1;
      tc    <= 1'b0;
    end else begin
      tc <= (cnt_q == '0);
      if (restart)            cnt_q <= restart_val;
      else if (cnt_q == '0)   cnt_q <= reload;
      else                    cnt_q <= cnt_q - 1'b1;
    end
  end

  // R4: terminal count cannot persist into a second clock while count is nonzero
  a_r4_tc_one_clock: assert property (@(posedge clk) disable iff (rst)
    (tc && cnt_q != '0) |=> !tc);
  // R3: zero count reloads the stored period
  a_r3_reload: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !restart) |=> (cnt_q == $past(reload)));
  // R3: a high-byte write loads the new period at once
  a_r3_restart: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == $past(restart_val)));
endmodule

// File: rtl/sg_sync_in.sv
module sg_sync_in (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  output logic level,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= sync_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign level = s2_q;
  assign rise  = s2_q & ~s3_q;

  // R6: an edge is detected once, never on two consecutive clocks
  a_r6_rise_single: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/sg_strobe.sv
module sg_strobe
  import psync_gen_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  sel_e sel,
  input  logic si_rise,
  input  logic tc,
  output logic clr
);
  always_ff @(posedge clk) begin
    if (rst) clr <= 1'b0;
    else begin
      unique case (sel)
        SEL_NEVER:  clr <= 1'b0;
        SEL_SYNCIN: clr <= si_rise;
        SEL_TC:     clr <= tc;
        SEL_ALWAYS: clr <= 1'b1;
        default:    clr <= 1'b0;
      endcase
    end
  end

  // R9: never selector keeps strobe low
  a_r9_never_quiet: assert property (@(posedge clk) disable iff (rst)
    ($past(sel) == SEL_NEVER) |-> !clr);
  // R8: always selector keeps strobe high
  a_r8_always_high: assert property (@(posedge clk) disable iff (rst)
    ($past(sel) == SEL_ALWAYS) |-> clr);
  // R7: terminal-count selector strobes after each pulse
  a_r7_tc_follow: assert property (@(posedge clk) disable iff (rst)
    ($past(sel) == SEL_TC && $past(tc)) |-> clr);
endmodule

// File: rtl/psync_gen.sv
module psync_gen
  import psync_gen_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [7:0]   wr_data,
  input  logic         sync_in,
  output logic         sync_out,
  output logic [3:0]   sub_clr
);
  sel_e                     out_src;
  logic                     os_en;
  logic [NUM_SUB*SEL_W-1:0] sel_vec;
  logic [CNT_W-1:0]         reload;
  logic                     restart;
  logic [CNT_W-1:0]         restart_val;
  logic                     os_pulse;
  logic                     tc;
  logic                     si_level;
  logic                     si_rise;
  logic                     src_bit;

  sg_regs #(.AW(ADDR_W), .CW(CNT_W), .NSUB(NUM_SUB)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_src(out_src), .os_en(os_en), .sel_vec(sel_vec), .reload(reload),
    .restart(restart), .restart_val(restart_val), .os_pulse(os_pulse)
  );

  sg_counter #(.CW(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .reload(reload), .restart(restart),
    .restart_val(restart_val), .tc(tc)
  );

  sg_sync_in sin_i (
    .clk(clk), .rst(rst), .sync_in(sync_in), .level(si_level), .rise(si_rise)
  );

  for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
    sg_strobe stb_i (
      .clk(clk), .rst(rst), .sel(sel_e'(sel_vec[g*SEL_W +: SEL_W])),
      .si_rise(si_rise), .tc(tc), .clr(sub_clr[g])
    );
  end

  always_comb begin
    unique case (out_src)
      SEL_NEVER:  src_bit = 1'b0;
      SEL_SYNCIN: src_bit = si_level;
      SEL_TC:     src_bit = tc;
      SEL_ALWAYS: src_bit = 1'b1;
      default:    src_bit = 1'b0;
    endcase
  end

  assign sync_out = src_bit | (os_pulse & os_en);

  // R11: a disabled one-shot cannot raise a quiet output
  a_r11_oneshot_gated: assert property (@(posedge clk) disable iff (rst)
    (out_src == SEL_NEVER && !os_en) |-> !sync_out);
endmodule

// File: tb/psync_gen_tb_top.sv
`timescale 1ns/1ps
module psync_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sync_in = 1'b0;
  logic       sync_out;
  logic [3:0] sub_clr;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  psync_gen dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_in(sync_in), .sync_out(sync_out), .sub_clr(sub_clr)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sync_out", sync_out, 0);
    check("R1 sub_clr", sub_clr, 0);

    // R3, R4, R5 (source 2), R7: period sweep with all selectors on terminal count
    wr(3'd0, 8'h02);
    wr(3'd1, 8'hAA);
    for (int v = 1; v <= 12; v++) begin
      wr(3'd2, 8'(v));
      wr(3'd3, 8'h00);
      for (int k = 1; k <= 3 * (v + 1); k++) begin
        @(negedge clk);
        check("R3/R4 sync_out", sync_out, (k % (v + 1) == 0) ? 1 : 0);
        if (k >= 2) check("R7 sub_clr", sub_clr, ((k - 1) % (v + 1) == 0) ? 15 : 0);
      end
    end

    // R6, R8, R9, R5 (source 1): selector rotation with a sync_in pulse
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'hFF);
    wr(3'd0, 8'h01);
    for (int s = 0; s < 4; s++) begin
      int a2 = (s + 1) % 4;
      wr(3'd1, 8'((1 << (2 * s)) | (3 << (2 * a2))));
      sync_in = 1'b1;
      for (int j = 0; j <= 6; j++) begin
        @(negedge clk);
        check("R6/R8/R9 sub_clr", sub_clr, ((j == 2) ? (1 << s) : 0) | (1 << a2));
        check("R5 sync_out level", sync_out, (j >= 1 && j <= 3) ? 1 : 0);
        if (j == 2) sync_in = 1'b0;
      end
    end

    // R10: enabled one-shot
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h04);
    wr(3'd4, 8'h01);
    check("R10 pulse", sync_out, 1);
    @(negedge clk);
    check("R10 self-clear", sync_out, 0);
    check("R2 selectors zero", sub_clr, 0);

    // R11: disabled one-shot
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h01);
    check("R11 no pulse", sync_out, 0);
    @(negedge clk);
    check("R11 still low", sync_out, 0);

    // R5: source 3 holds high
    wr(3'd0, 8'h03);
    check("R5 always high", sync_out, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule